// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the address and count registers for four DMA channels. It holds, per channel, a 16-bit base address, a 16-bit base count, a live current address, and a progress count that tells how far the transfer has gone. A host reaches every register through byte-wide accesses. One byte-pointer flip-flop, shared by all channel registers, decides whether an access touches the low byte or the high byte. Every access flips the pointer, so a 16-bit value is written or read as two accesses in a row, low byte first.

Completing the high byte of either base register rearms the channel. The current address is loaded from the base address, and the progress count returns to zero. A read does not return a stored register. It returns a live value: the current address moved by the progress count, in the direction that the channel's mode bit selects, or the number of units still to transfer.

A word-shift parameter adapts the block to a controller that moves 16-bit words. That parameter sets which host address bits form the port index, and it scales the address and count values. The transfer engine sits outside the block and writes each channel's progress through a dedicated input. The control logic clears the pointer through a separate input.

Top module: `dma_chan_regfile`

## Requirements
- R1: Port index decode.
  - The port index is the 4-bit field host_addr[SHIFT+3:SHIFT]. Index bits [3:1] give the channel number. Index bit 0 selects the address register when 0 and the count register when 1.
  - An index whose channel number is NUM_CH or higher leaves every register unchanged, and a read of it returns 0x00. The byte pointer still flips on such an access.
- R2: The byte pointer is 0 after reset. Each read or write uses the current pointer value and then flips it. Value 0 selects the low byte and value 1 selects the high byte.
- R3: A write with the pointer at 0 replaces bits [7:0] of the addressed base register. It does not change the current address or the progress count.
- R4: A write with the pointer at 1 replaces bits [15:8] of the addressed base register. The same write, to either register of the channel, loads the current address with the new base address shifted left by SHIFT and clears the progress count to zero.
- R5: A count read yields (base count << SHIFT) − progress.
- R6: An address read yields current address + progress when the channel's chan_dir bit is 0, and current address − progress when it is 1.
- R7: Read timing and byte selection.
  - The byte returned is (value >> (SHIFT + 8·pointer)) & 0xFF, where value comes from R5 or R6.
  - That byte appears on rd_data, with rd_valid high, in the cycle after the read. Between reads, rd_data holds its last value.
- R8: ff_clear forces the pointer to 0 on the next edge. It overrides the flip caused by an access in the same cycle, and that access still uses the old pointer value.
- R9: When host_wr and host_rd are high together, only the write takes place. The pointer flips once, and rd_valid stays low in the next cycle.
- R10: Progress input.
  - xfer_we loads xfer_pos into the progress count of channel xfer_chan.
  - If a high-byte write to the same channel occurs in the same cycle, the write's clearing to zero wins.
- R11: Synchronous reset clears all base registers, current addresses, progress counts, the pointer, rd_data and rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ff_clear | input | 1 | Forces the byte pointer to zero |
| host_addr | input | ADDR_W (4+SHIFT) | Host port address, index taken at bit SHIFT |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_wdata | input | 8 | Host write byte |
| chan_dir | input | NUM_CH | Per-channel address-decrement mode bit |
| xfer_we | input | 1 | Progress count load strobe from the transfer engine |
| xfer_chan | input | log2(NUM_CH) | Channel whose progress is loaded |
| xfer_pos | input | 17+SHIFT | New progress count |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data was updated by a read in the previous cycle |

## Verification
The hardest situations to reach from the ports depend on the hidden pointer phase coinciding with other events. Examples are a progress load landing in the same cycle as a high-byte write to the same channel, and a pointer clear arriving during an access. Directed sequences place a clear first, which fixes the phase. They then issue the exact access pair that lands the high byte on the cycle of interest. A long random run follows, mixing clears, collisions, out-of-range indices and direction changes. A behavioural model tracks the pointer and checks every cycle. Two instances, one unshifted and one word-shifted, receive identical stimulus.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;
  localparam int BASE_W = 16;
  localparam int CHN_W  = IDX_W - 1;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic [CHN_W-1:0] chan;
    reg_sel_e         sel;
  } port_idx_t;

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  parameter int ADDR_W = IDX_W + SHIFT
) (
  input  logic [ADDR_W-1:0] host_addr,
  output port_idx_t         idx_o,
  output logic              hit_o
);

  logic [IDX_W-1:0] win;

  always_comb begin
    win        = host_addr[SHIFT +: IDX_W];
    idx_o.chan = win[IDX_W-1:1];
    idx_o.sel  = reg_sel_e'(win[0]);
    hit_o      = (int'(win[IDX_W-1:1]) < NUM_CH);
  end

endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic access,
  output logic ptr_o
);

  logic ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) ptr_q <= 1'b0;
    else if (access) ptr_q <= ~ptr_q;
  end

  assign ptr_o = ptr_q;

  AST_PTR_FLIP: assert property (@(posedge clk) disable iff (rst)
    (access && !clr) |=> (ptr_q != $past(ptr_q))); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> !ptr_q); // R8

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_rf_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int CUR_W  = BASE_W + SHIFT,
  parameter int PROG_W = CUR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              xfer_we,
  input  logic [PROG_W-1:0] xfer_pos,
  input  logic              dir,
  output logic [PROG_W-1:0] addr_live,
  output logic [PROG_W-1:0] cnt_live
);

  logic [BASE_W-1:0] base_addr_q, base_cnt_q;
  logic [BASE_W-1:0] base_addr_d, base_cnt_d;
  logic [CUR_W-1:0]  cur_addr_q;
  logic [PROG_W-1:0] prog_q;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (wr_lo) begin
      if (sel == SEL_ADDR) base_addr_d[BYTE_W-1:0] = wdata;
      else                 base_cnt_d[BYTE_W-1:0]  = wdata;
    end
    if (wr_hi) begin
      if (sel == SEL_ADDR) base_addr_d[BASE_W-1:BYTE_W] = wdata;
      else                 base_cnt_d[BASE_W-1:BYTE_W]  = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      prog_q      <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      if (wr_hi) begin
        cur_addr_q <= CUR_W'(base_addr_d) << SHIFT;
        prog_q     <= '0;
      end else if (xfer_we) begin
        prog_q <= xfer_pos;
      end
    end
  end

  always_comb begin
    addr_live = dir ? (PROG_W'(cur_addr_q) - prog_q)
                    : (PROG_W'(cur_addr_q) + prog_q);
    cnt_live  = (PROG_W'(base_cnt_q) << SHIFT) - prog_q;
  end

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (prog_q == '0)); // R4
  AST_LO_KEEPS_CUR: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> $stable(cur_addr_q)); // R3
  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (xfer_we && !wr_hi) |=> (prog_q == $past(xfer_pos))); // R10

endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int SHIFT   = 0,
  parameter int ADDR_W  = IDX_W + SHIFT,
  parameter int CSEL_W  = $clog2(NUM_CH),
  parameter int PROG_W  = BASE_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ff_clear,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [NUM_CH-1:0] chan_dir,
  input  logic              xfer_we,
  input  logic [CSEL_W-1:0] xfer_chan,
  input  logic [PROG_W-1:0] xfer_pos,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);

  port_idx_t         idx;
  logic              hit;
  logic              ptr;
  logic              access, do_rd;
  logic [PROG_W-1:0] addr_live [NUM_CH];
  logic [PROG_W-1:0] cnt_live  [NUM_CH];
  logic [PROG_W-1:0] rd_word;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] rd_data_q;
  logic              rd_valid_q;

  assign access = host_wr | host_rd;
  assign do_rd  = host_rd & ~host_wr;

  dma_port_decode #(.NUM_CH(NUM_CH), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_dec (
    .host_addr (host_addr),
    .idx_o     (idx),
    .hit_o     (hit)
  );

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst    (rst),
    .clr    (ff_clear),
    .access (access),
    .ptr_o  (ptr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic this_ch;
    assign this_ch = hit && (idx.chan == CHN_W'(g));

    dma_chan_regs #(.SHIFT(SHIFT)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_lo     (host_wr & this_ch & ~ptr),
      .wr_hi     (host_wr & this_ch & ptr),
      .sel       (idx.sel),
      .wdata     (host_wdata),
      .xfer_we   (xfer_we && (xfer_chan == CSEL_W'(g))),
      .xfer_pos  (xfer_pos),
      .dir       (chan_dir[g]),
      .addr_live (addr_live[g]),
      .cnt_live  (cnt_live[g])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && (idx.chan == CHN_W'(c)))
        rd_word = (idx.sel == SEL_CNT) ? cnt_live[c] : addr_live[c];
    end
    rd_byte = BYTE_W'(rd_word >> (SHIFT + (ptr ? BYTE_W : 0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= do_rd;
      if (do_rd) rd_data_q <= rd_byte;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> rd_valid); // R7
  AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> !rd_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(rd_data)); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (do_rd && !hit) |=> (rd_data == '0)); // R1

endmodule

// File: tb/tb_dma_chan_regfile.sv
module tb_dma_chan_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ff_clear = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  dir = '0;
  logic        xfer_we = 1'b0;
  logic [1:0]  xfer_chan = '0;
  logic [17:0] xfer_pos = '0;
  logic [7:0]  rd_data [2];
  logic        rd_valid [2];
  logic [7:0]  q0, q1;
  logic        v0, v1;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string tag = "R11";

  logic [15:0] m_base [2][4][2];
  logic [31:0] m_cur  [2][4];
  logic [31:0] m_prog [2][4];
  logic        m_ptr  [2];
  logic        m_vld  [2];
  logic [7:0]  m_dat  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regfile #(.NUM_CH(4), .SHIFT(0)) dut (
    .clk(clk), .rst(rst), .ff_clear(ff_clear), .host_addr(idx),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(wdata),
    .chan_dir(dir), .xfer_we(xfer_we), .xfer_chan(xfer_chan),
    .xfer_pos(xfer_pos[16:0]), .rd_data(q0), .rd_valid(v0));

  dma_chan_regfile #(.NUM_CH(4), .SHIFT(1)) dut_w (
    .clk(clk), .rst(rst), .ff_clear(ff_clear), .host_addr({idx, 1'b0}),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(wdata),
    .chan_dir(dir), .xfer_we(xfer_we), .xfer_chan(xfer_chan),
    .xfer_pos(xfer_pos), .rd_data(q1), .rd_valid(v1));

  assign rd_data[0] = q0;  assign rd_data[1] = q1;
  assign rd_valid[0] = v0; assign rd_valid[1] = v1;

  task automatic model_step();
    for (int s = 0; s < 2; s++) begin
      int ch;
      int sel;
      logic [31:0] val;
      if (rst) begin
        for (int c = 0; c < 4; c++) begin
          m_base[s][c][0] = '0; m_base[s][c][1] = '0;
          m_cur[s][c] = '0; m_prog[s][c] = '0;
        end
        m_ptr[s] = 0; m_vld[s] = 0; m_dat[s] = '0;
        continue;
      end
      ch  = int'(idx[3:1]);
      sel = int'(idx[0]);
      m_vld[s] = host_rd && !host_wr;
      if (m_vld[s]) begin
        if (ch < 4) begin
          if (sel == 1) val = (32'(m_base[s][ch][1]) << s) - m_prog[s][ch];
          else if (dir[ch]) val = m_cur[s][ch] - m_prog[s][ch];
          else val = m_cur[s][ch] + m_prog[s][ch];
          m_dat[s] = 8'((val >> (s + (m_ptr[s] ? 8 : 0))) & 32'hFF);
        end else begin
          m_dat[s] = 8'h00;
        end
      end
      if (xfer_we) m_prog[s][xfer_chan] = 32'(xfer_pos);
      if (host_wr && ch < 4) begin
        if (!m_ptr[s]) m_base[s][ch][sel][7:0] = wdata;
        else begin
          m_base[s][ch][sel][15:8] = wdata;
          m_cur[s][ch]  = 32'(m_base[s][ch][0]) << s;
          m_prog[s][ch] = '0;
        end
      end
      if (ff_clear) m_ptr[s] = 0;
      else if (host_wr || host_rd) m_ptr[s] = ~m_ptr[s];
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      vectors++;
      if (rd_valid[s] !== m_vld[s] || rd_data[s] !== m_dat[s]) begin
        miscompares++;
        $display("FAIL %s shift%0d: valid %0b data %02h, expected valid %0b data %02h",
                 tag, s, rd_valid[s], rd_data[s], m_vld[s], m_dat[s]);
      end
    end
    host_wr = 0; host_rd = 0; ff_clear = 0; xfer_we = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    idx = i; wdata = d; host_wr = 1; tick();
  endtask
  task automatic rd(input logic [3:0] i);
    idx = i; host_rd = 1; tick();
  endtask
  task automatic clr();
    ff_clear = 1; tick();
  endtask
  task automatic xfer(input logic [1:0] c, input logic [17:0] p);
    xfer_we = 1; xfer_chan = c; xfer_pos = p; tick();
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tag = "R11"; tick(); tick();
    rst = 0;
    rd(4'd0); rd(4'd0); rd(4'd1);                   // R11 reset state
    clr();
    tag = "R3"; wr(4'd4, 8'h34);                    // R3 low byte only
    rd(4'd4); clr(); rd(4'd4);
    clr(); tag = "R4"; wr(4'd4, 8'h34); wr(4'd4, 8'h12);
    tag = "R2"; rd(4'd4); rd(4'd4);                 // R2 low then high
    tag = "R4"; wr(4'd5, 8'h00); wr(4'd5, 8'h01);   // R4 count high reloads
    tag = "R10"; xfer(2'd2, 18'd5);
    tag = "R5"; rd(4'd5); rd(4'd5);                 // R5
    tag = "R6"; rd(4'd4); rd(4'd4);
    dir[2] = 1; rd(4'd4); rd(4'd4); dir[2] = 0;     // R6 decrement
    tag = "R3"; wr(4'd4, 8'h99); rd(4'd4); rd(4'd4);// R3 no reload
    tag = "R8"; rd(4'd6); clr(); rd(4'd4);          // R8
    idx = 4'd4; host_rd = 1; ff_clear = 1; tick(); rd(4'd4);
    tag = "R9"; idx = 4'd2; wdata = 8'h77; host_wr = 1; host_rd = 1; tick();
    rd(4'd2); clr(); rd(4'd2); rd(4'd2);            // R9
    tag = "R1"; wr(4'd9, 8'hAA); rd(4'd13); rd(4'd0);
    rd(4'd0); wr(4'd12, 8'h55); rd(4'd1);           // R1 ignored index
    tag = "R10"; clr(); xfer(2'd1, 18'd7); wr(4'd2, 8'h10);
    xfer_we = 1; xfer_chan = 2'd1; xfer_pos = 18'd3; idx = 4'd2; wdata = 8'h20; host_wr = 1; tick();
    rd(4'd2); rd(4'd2);                             // R10 reload wins
    tag = "R7";
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      idx = 4'($urandom); wdata = 8'($urandom); dir = 4'($urandom);
      if (op < 4) host_rd = 1;
      else if (op < 7) host_wr = 1;
      else if (op == 7) begin host_rd = 1; host_wr = 1; end
      ff_clear = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) begin
        xfer_we = 1; xfer_chan = 2'($urandom); xfer_pos = 18'($urandom_range(0, 4095));
      end
      tick();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule